// File: doc/BRIEF.md
# Serial Receiver with Line Status Word

This block turns an asynchronous serial input into characters of five to eight bits. A rate enable pulsed sixteen times per bit period paces it. A falling edge on the idle-high line starts a candidate frame. The candidate counts as a real start only if the line is still low at mid-bit. After that, every data, parity and stop bit is sampled once, in the middle of its bit time. Character length and parity are set by static inputs.

Each finished character goes into a receive queue together with its own error flags. Software switches the queue between a shallow setting of 16 entries and a deep setting of 64 entries. The host reads the head of the queue through a pop strobe. The host reads an 8-bit status word through a separate strobe, and that strobe clears the error flags that are sticky. The two transmitter-empty bits of the status word come in through ports and pass straight through. A receive-ready output follows the queue occupancy so that it can drive an interrupt line.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset the queue is empty, `rx_ready` is 0, and status bits 0, 1, 2, 3, 4 and 7 are 0.
- R2: A low level on `rx_in` counts as a start bit only if the line is still low 8 ticks after the low was first seen. A low pulse shorter than that stores no character.
- R3: Data bits arrive LSB first. `word_len` sets the length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of `rx_data` read 0. One parity bit follows the data when `parity_en` is 1, and one stop bit is sampled after that. Each bit is sampled 16 ticks after the previous sample.
- R4: Status bit 0 and `rx_ready` are 1 while the queue holds at least one character. `rd_data` removes the head character, and both signals return to 0 once the queue is empty.
- R5: Status bit 1 (overrun) sets when a character completes while the queue is full. That character is dropped, the queue contents are unchanged, and the bit clears on a status read.
- R6: Status bit 2 sets on a parity mismatch and clears on a status read. With `parity_even`=1 the data bits and the parity bit together carry an even number of ones. With `parity_even`=0 they carry an odd number.
- R7: Status bit 3 (framing) sets when the stop bit is sampled as 0 and clears on a status read.
- R8: Status bit 4 (break) sets when the data bits, the parity bit if present, and the stop bit are all 0. Bit 3 is also set. A zero character is stored. The receiver then waits for the line to go high before it looks for another start bit. Bit 4 clears on a status read.
- R9: Status bit 5 equals `thr_empty` and status bit 6 equals `tsr_empty` in every cycle.
- R10: Status bit 7 sets when a character with a parity, framing or break flag is stored. A status read clears it only if no such character is left in the queue.
- R11: With `deep_fifo`=0 the queue holds 16 characters. With `deep_fifo`=1 it holds 64.
- R12: Characters leave the queue in the order in which they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit period |
| rx_in | input | 1 | Serial input, idle high |
| word_len | input | 2 | Character length code (00=5 … 11=8 bits) |
| parity_en | input | 1 | 1 = a parity bit follows the data |
| parity_even | input | 1 | 1 = even parity, 0 = odd parity |
| deep_fifo | input | 1 | 1 = 64-entry queue, 0 = 16-entry queue |
| rd_data | input | 1 | Pop the head character (one-cycle strobe) |
| rd_lsr | input | 1 | Status word read (one-cycle strobe), clears sticky flags |
| thr_empty | input | 1 | Transmit holding register empty, passed to bit 5 |
| tsr_empty | input | 1 | Transmit shift register empty, passed to bit 6 |
| rx_data | output | 8 | Head character of the queue, 0 when empty |
| lsr | output | 8 | Status word: {err_in_queue, tsr_empty, thr_empty, break, framing, parity, overrun, data_ready} |
| rx_ready | output | 1 | High while a received character is waiting |

## Verification
The hardest condition to reach is status bit 7 while the queue still holds an errored character behind a good one, since R10 then requires the bit to survive a status read. The bench stores a character with bad parity and then a clean one, reads the status word twice before any pop, drains the queue, and reads once more to see the bit drop. Overrun at both depths needs the queue filled to its exact limit plus one. The bench streams 17 frames in the shallow setting and 65 in the deep one without popping, then drains and checks that the first characters are still in place.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // One received character and the errors seen while framing it.
    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAITHI
    } rx_state_e;

    // Index of the last data bit: 5 bits -> 4 ... 8 bits -> 7.
    function automatic logic [2:0] last_bit_idx(input logic [1:0] wl);
        return {1'b1, wl};
    endfunction

    function automatic logic has_error(input rx_char_t c);
        return c.brk | c.ferr | c.perr;
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int MID_TICKS = 8,
    parameter int BIT_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic       parity_even,
    output logic       done,
    output rx_char_t   char_o
);
    localparam int CW = $clog2(BIT_TICKS);
    localparam logic [CW-1:0] MID_LAST = CW'(MID_TICKS - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(BIT_TICKS - 1);

    logic [1:0]  sync_q;
    logic        rxs;
    rx_state_e   state;
    logic [CW-1:0] cnt;
    logic [2:0]  idx;
    logic [7:0]  data_q;
    logic        par_q;
    logic        ones_odd;

    assign rxs      = sync_q[1];
    assign ones_odd = (^data_q) ^ par_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rx_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_HUNT;
            cnt    <= '0;
            idx    <= '0;
            data_q <= '0;
            par_q  <= 1'b0;
            done   <= 1'b0;
            char_o <= '0;
        end else begin
            done <= 1'b0;
            if (tick16) begin
                case (state)
                    ST_HUNT: begin
                        if (!rxs) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID_LAST) begin
                            cnt    <= '0;
                            idx    <= '0;
                            data_q <= '0;
                            par_q  <= 1'b0;
                            state  <= rxs ? ST_HUNT : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == BIT_LAST) begin
                            cnt         <= '0;
                            data_q[idx] <= rxs;
                            if (idx == last_bit_idx(word_len))
                                state <= parity_en ? ST_PAR : ST_STOP;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == BIT_LAST) begin
                            cnt   <= '0;
                            par_q <= rxs;
                            state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == BIT_LAST) begin
                            cnt         <= '0;
                            done        <= 1'b1;
                            char_o.data <= data_q;
                            char_o.perr <= parity_en & (ones_odd ^ ~parity_even);
                            char_o.ferr <= ~rxs;
                            char_o.brk  <= ~rxs & (data_q == 8'h00) & ~par_q;
                            state       <= rxs ? ST_HUNT : ST_WAITHI;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WAITHI: begin
                        if (rxs) state <= ST_HUNT;
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    // R3: a character completion lasts exactly one cycle
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a break character always carries a framing error
    assert_brk_has_ferr_R8: assert property (@(posedge clk) disable iff (rst)
        done && char_o.brk |-> char_o.ferr);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH_MAX = 64,
    parameter int DEPTH_MIN = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     deep,
    input  logic     push,
    input  rx_char_t push_char,
    input  logic     pop,
    output rx_char_t head,
    output logic     empty,
    output logic     full,
    output logic     err_any
);
    localparam int AW = $clog2(DEPTH_MAX);
    localparam int CW = $clog2(DEPTH_MAX + 1);
    localparam logic [CW-1:0] LIM_DEEP    = CW'(DEPTH_MAX);
    localparam logic [CW-1:0] LIM_SHALLOW = CW'(DEPTH_MIN);

    rx_char_t      mem [DEPTH_MAX];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count, err_cnt;
    logic          do_push, do_pop, push_err, pop_err;

    assign empty    = (count == '0);
    assign full     = count >= (deep ? LIM_DEEP : LIM_SHALLOW);
    assign head     = mem[rd_ptr];
    assign do_push  = push & ~full;
    assign do_pop   = pop & ~empty;
    assign push_err = do_push & has_error(push_char);
    assign pop_err  = do_pop & has_error(head);
    assign err_any  = (err_cnt != '0);

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_char;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count   <= count + CW'(do_push) - CW'(do_pop);
            err_cnt <= err_cnt + CW'(push_err) - CW'(pop_err);
        end
    end

    // R11: occupancy never goes past the largest setting
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        count <= LIM_DEEP);

    // R5: a character arriving at a full queue leaves the occupancy unchanged
    assert_full_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        push && full && !pop |=> count == $past(count));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     done,
    input  rx_char_t done_char,
    input  logic     q_full,
    input  logic     q_empty,
    input  logic     q_err_any,
    input  logic     rd_lsr,
    input  logic     thr_empty,
    input  logic     tsr_empty,
    output logic [7:0] lsr
);
    logic oe_q, pe_q, fe_q, bi_q, qe_q;
    logic stored, dropped;

    assign stored  = done & ~q_full;
    assign dropped = done & q_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
            pe_q <= 1'b0;
            fe_q <= 1'b0;
            bi_q <= 1'b0;
            qe_q <= 1'b0;
        end else begin
            oe_q <= dropped | (oe_q & ~rd_lsr);
            pe_q <= (stored & done_char.perr) | (pe_q & ~rd_lsr);
            fe_q <= (stored & done_char.ferr) | (fe_q & ~rd_lsr);
            bi_q <= (stored & done_char.brk)  | (bi_q & ~rd_lsr);
            if (stored && has_error(done_char)) qe_q <= 1'b1;
            else if (rd_lsr)                    qe_q <= q_err_any;
        end
    end

    assign lsr = {qe_q, tsr_empty, thr_empty, bi_q, fe_q, pe_q, oe_q, ~q_empty};

    // R5: a status read with no new overrun clears bit 1
    assert_oe_clears_R5: assert property (@(posedge clk) disable iff (rst)
        rd_lsr && !dropped |=> !oe_q);

    // R7: a stored character with a bad stop bit raises bit 3
    assert_fe_sets_R7: assert property (@(posedge clk) disable iff (rst)
        stored && done_char.ferr |=> fe_q);

    // R8: break is never reported without framing error
    assert_brk_implies_fe_R8: assert property (@(posedge clk) disable iff (rst)
        bi_q |-> fe_q);

    // R10: an errored entry in the queue keeps bit 7 up
    assert_qerr_held_R10: assert property (@(posedge clk) disable iff (rst)
        q_err_any |-> qe_q);

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int DEPTH_MAX = 64,
    parameter int DEPTH_MIN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic       parity_even,
    input  logic       deep_fifo,
    input  logic       rd_data,
    input  logic       rd_lsr,
    input  logic       thr_empty,
    input  logic       tsr_empty,
    output logic [7:0] rx_data,
    output logic [7:0] lsr,
    output logic       rx_ready
);
    logic     done, q_empty, q_full, q_err_any;
    rx_char_t done_char, head;

    uart_rx_frame u_frame (
        .clk         (clk),
        .rst         (rst),
        .tick16      (tick16),
        .rx_in       (rx_in),
        .word_len    (word_len),
        .parity_en   (parity_en),
        .parity_even (parity_even),
        .done        (done),
        .char_o      (done_char)
    );

    uart_rx_fifo #(
        .DEPTH_MAX (DEPTH_MAX),
        .DEPTH_MIN (DEPTH_MIN)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .deep      (deep_fifo),
        .push      (done),
        .push_char (done_char),
        .pop       (rd_data),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full),
        .err_any   (q_err_any)
    );

    uart_rx_status u_status (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .done_char (done_char),
        .q_full    (q_full),
        .q_empty   (q_empty),
        .q_err_any (q_err_any),
        .rd_lsr    (rd_lsr),
        .thr_empty (thr_empty),
        .tsr_empty (tsr_empty),
        .lsr       (lsr)
    );

    assign rx_data  = q_empty ? 8'h00 : head.data;
    assign rx_ready = ~q_empty;

endmodule

// File: tb/uart_rx_lsr_tb_top.sv
module uart_rx_lsr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16;
    logic       rx_line = 1'b1;
    logic [1:0] word_len = 2'b11;
    logic       parity_en = 1'b0;
    logic       parity_even = 1'b0;
    logic       deep_fifo = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_lsr = 1'b0;
    logic       thr_empty = 1'b1;
    logic       tsr_empty = 1'b1;
    logic [7:0] rx_data, lsr;
    logic       rx_ready;
    logic [1:0] tick_div;
    logic       run_chk = 1'b0;

    int checks = 0;
    int failures = 0;

    // Reference model: queue of {brk, ferr, perr, data}
    logic [10:0] mq [$];
    logic m_oe = 1'b0, m_pe = 1'b0, m_fe = 1'b0, m_bi = 1'b0, m_b7 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) tick_div <= '0;
        else     tick_div <= tick_div + 2'd1;
    end
    assign tick16 = (tick_div == 2'd3);

    uart_rx_lsr dut_i (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_line),
        .word_len(word_len), .parity_en(parity_en), .parity_even(parity_even),
        .deep_fifo(deep_fifo), .rd_data(rd_data), .rd_lsr(rd_lsr),
        .thr_empty(thr_empty), .tsr_empty(tsr_empty),
        .rx_data(rx_data), .lsr(lsr), .rx_ready(rx_ready)
    );

    // Every-clock comparison: R9 pass-through and R4 ready/bit 0 agreement
    always @(negedge clk) begin
        if (run_chk) begin
            checks++;
            if (lsr[6:5] !== {tsr_empty, thr_empty}) begin
                failures++;
                $display("FAIL R9 lsr[6:5]=%b expected %b", lsr[6:5], {tsr_empty, thr_empty});
            end
            checks++;
            if (rx_ready !== lsr[0]) begin
                failures++;
                $display("FAIL R4 rx_ready=%b expected %b", rx_ready, lsr[0]);
            end
        end
    end

    function automatic logic [7:0] model_lsr();
        return {m_b7, tsr_empty, thr_empty, m_bi, m_fe, m_pe, m_oe, (mq.size() > 0)};
    endfunction

    function automatic logic any_err_in_q();
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!tick16) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stopv, input logic flip);
        int nb;
        logic [7:0] md;
        logic pbit;
        logic [10:0] ent;
        int lim;
        nb   = 5 + int'(word_len);
        md   = d & 8'((1 << nb) - 1);
        pbit = (parity_even ? ^md : ~^md) ^ flip;
        rx_line = 1'b0; wait_ticks(16);
        for (int i = 0; i < nb; i++) begin
            rx_line = md[i]; wait_ticks(16);
        end
        if (parity_en) begin
            rx_line = pbit; wait_ticks(16);
        end
        rx_line = stopv; wait_ticks(16);
        rx_line = 1'b1; wait_ticks(32);
        ent[7:0] = md;
        ent[8]   = parity_en & flip;
        ent[9]   = ~stopv;
        ent[10]  = ~stopv & (md == 8'h00) & ~(parity_en & pbit);
        lim = deep_fifo ? 64 : 16;
        if (mq.size() < lim) begin
            mq.push_back(ent);
            m_pe |= ent[8];
            m_fe |= ent[9];
            m_bi |= ent[10];
            if (ent[10:8] != 3'b000) m_b7 = 1'b1;
        end else begin
            m_oe = 1'b1;
        end
    endtask

    task automatic read_lsr(input string tag);
        check8(tag, lsr, model_lsr());
        rd_lsr = 1'b1;
        @(negedge clk);
        rd_lsr = 1'b0;
        m_oe = 1'b0; m_pe = 1'b0; m_fe = 1'b0; m_bi = 1'b0;
        m_b7 = any_err_in_q();
    endtask

    task automatic pop_char(input string tag);
        check8(tag, rx_data, mq.size() > 0 ? mq[0][7:0] : 8'h00);
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        run_chk = 1'b1;

        // R1: reset state
        check8("R1 lsr after reset", lsr, 8'h60);
        check8("R1 rx_ready after reset", {7'd0, rx_ready}, 8'h00);

        // R3/R4/R12: 8N1 characters
        send_frame(8'hA5, 1'b1, 1'b0);
        send_frame(8'h3C, 1'b1, 1'b0);
        read_lsr("R4 data ready set");
        pop_char("R12 first char");
        pop_char("R12 second char");
        read_lsr("R4 data ready clear");

        // R9: pass-through under changed inputs
        thr_empty = 1'b0; tsr_empty = 1'b1;
        @(negedge clk);
        check8("R9 thr low", lsr, model_lsr());
        thr_empty = 1'b1; tsr_empty = 1'b0;
        @(negedge clk);
        check8("R9 tsr low", lsr, model_lsr());
        tsr_empty = 1'b1;

        // R6: 7-bit even parity good, odd parity bad
        word_len = 2'b10; parity_en = 1'b1; parity_even = 1'b1;
        send_frame(8'h55, 1'b1, 1'b0);
        read_lsr("R6 even parity ok");
        pop_char("R6 even char");
        parity_even = 1'b0;
        send_frame(8'h13, 1'b1, 1'b1);
        read_lsr("R6 parity error set");
        pop_char("R6 odd char");
        read_lsr("R6 parity error cleared");

        // R3: 5- and 6-bit lengths, upper bits zero
        parity_en = 1'b0;
        word_len = 2'b00;
        send_frame(8'hFF, 1'b1, 1'b0);
        pop_char("R3 5-bit char");
        word_len = 2'b01;
        send_frame(8'hEA, 1'b1, 1'b0);
        pop_char("R3 6-bit char");
        word_len = 2'b11;

        // R2: short low pulse ignored
        rx_line = 1'b0; wait_ticks(4);
        rx_line = 1'b1; wait_ticks(40);
        read_lsr("R2 glitch stores nothing");

        // R7: bad stop bit
        send_frame(8'h3C, 1'b0, 1'b0);
        read_lsr("R7 framing set");
        pop_char("R7 char kept");
        read_lsr("R7 framing cleared");

        // R8: line held low for longer than a character
        rx_line = 1'b0; wait_ticks(16 * 12);
        rx_line = 1'b1; wait_ticks(48);
        mq.push_back({3'b110, 8'h00});
        m_fe = 1'b1; m_bi = 1'b1; m_b7 = 1'b1;
        read_lsr("R8 break set");
        pop_char("R8 zero char");
        read_lsr("R8 break cleared");
        send_frame(8'h81, 1'b1, 1'b0);
        pop_char("R8 receiver resumes");

        // R10: bit 7 held while an errored entry remains
        parity_en = 1'b1; parity_even = 1'b1;
        send_frame(8'h0F, 1'b1, 1'b1);
        send_frame(8'h0E, 1'b1, 1'b0);
        read_lsr("R10 bit7 set");
        read_lsr("R10 bit7 kept with error queued");
        pop_char("R10 errored char");
        pop_char("R10 clean char");
        read_lsr("R10 bit7 before final read");
        read_lsr("R10 bit7 cleared");
        parity_en = 1'b0;

        // R5: overrun at 16 entries
        for (int i = 0; i < 17; i++) send_frame(8'(i + 8'h40), 1'b1, 1'b0);
        read_lsr("R5 overrun set");
        read_lsr("R5 overrun cleared");
        for (int i = 0; i < 16; i++) pop_char("R5 contents kept");

        // R11: deep setting holds 64
        deep_fifo = 1'b1;
        for (int i = 0; i < 64; i++) send_frame(8'(i * 3), 1'b1, 1'b0);
        read_lsr("R11 64 entries no overrun");
        send_frame(8'hEE, 1'b1, 1'b0);
        read_lsr("R11 65th overruns");
        for (int i = 0; i < 64; i++) pop_char("R11 deep contents");
        read_lsr("R4 empty after drain");

        run_chk = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule